// File: doc/BRIEF.md
# RTC Once-Per-Second Update Sequencer

This block paces the once-per-second time update of a PC-style real-time clock. A second prescaler counts enable ticks from a 32.768 kHz reference. A fixed number of ticks before each second boundary, the block raises an update-in-progress status bit. At the boundary it issues a single-cycle advance strobe to an external calendar counter. It then holds the update window open for a fixed number of ticks and closes it with a single-cycle update-ended pulse to the interrupt flag logic.

The host has two ways to stop the process. A set-mode input stops updates while the time registers are being loaded. A divider-reset input parks the whole sequencer. The update-in-progress bit is meant to be read as the top bit of the rate/status register. Software polls it and may touch the time registers only while it is low. The default timing is 8 ticks of warning (about 244 µs) followed by a 65-tick window (about 1.984 ms). With these values the bit is never high for more than about 2.228 ms.

Top module: `rtc_update_seq`

## Requirements
- R1: After reset, `uip`, `advance` and `update_end` are all 0, and the second prescaler starts from zero.
- R2: With no hold in force, exactly one `advance` strobe occurs for every TICKS_PER_SEC ticks. After reset or after a hold is released, the first strobe follows the TICKS_PER_SEC-th tick.
- R3: `uip` rises after the tick that lies WARN_TICKS ticks before the second boundary. It therefore stays high for exactly WARN_TICKS ticks before `advance` fires.
- R4: `advance` is a one-clock pulse. It fires only on entry to the update window, and `uip` is 1 while it fires.
- R5: The update window lasts UPD_TICKS ticks. `update_end` is a one-clock pulse after the last tick of the window, and `uip` is 0 from that same clock onward.
- R6: The parameters must satisfy TICKS_PER_SEC > 2*WARN_TICKS + UPD_TICKS. This leaves at least WARN_TICKS idle ticks between the fall of `uip` and its next rise.
- R7: If `set_mode` is 1 during the warning phase, the cycle is abandoned. `uip` goes to 0 on the next clock, and neither `advance` nor `update_end` fires for that cycle.
- R8: If `set_mode` becomes 1 during the update window, the window runs to its end and `update_end` still fires.
- R9: While `set_mode` is 1, the prescaler is held at zero and no new cycle starts. The first `advance` after `set_mode` clears comes on the TICKS_PER_SEC-th tick.
- R10: While `div_reset` is 1, `uip` reads 0 in the same clock. The sequencer returns to idle and the prescaler is held at zero. No `advance` or `update_end` fires, even if a window was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock enable per reference period (32.768 kHz) |
| set_mode | input | 1 | Host clock-setting mode; inhibits updates |
| div_reset | input | 1 | Divider chain held in reset |
| uip | output | 1 | Update-in-progress status (top bit of rate/status register) |
| advance | output | 1 | One-clock strobe to the calendar counter |
| update_end | output | 1 | One-clock pulse to the update-ended flag |

## Verification
The embedded properties check several rules on every clock. `advance` may only appear on the step from warning to update. `update_end` may only appear on the step from update to idle. A set-mode request must abort a warning phase but leave an open window alone. Divider reset must force idle with `uip` low. The window counter must stay inside its phase's length, and a hold must zero the prescaler. Some behaviour can only be shown by the bench's tick-counted scenarios. These are the exact distance in ticks from the `uip` rise to the strobe, the window length, the full-second delay after a hold is released, and the steady one-strobe-per-second rate.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_WARN   = 2'd1,
      PH_UPDATE = 2'd2
   } upd_phase_e;
endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned PW            = $clog2(TICKS_PER_SEC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          hold,
   output logic [PW-1:0] cnt
);
   localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
   localparam bit IS_POW2 = ((TICKS_PER_SEC & (TICKS_PER_SEC - 1)) == 0);

   initial begin
      AST_PRE_WIDTH: assert ((1 << PW) >= TICKS_PER_SEC)
         else $error("prescaler width too small"); // R2
   end

   generate
      if (IS_POW2) begin : g_pow2
         // natural wrap of a full-width counter
         always_ff @(posedge clk) begin
            if (!rst_n)     cnt <= '0;
            else if (hold)  cnt <= '0;
            else if (tick)  cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)     cnt <= '0;
            else if (hold)  cnt <= '0;
            else if (tick)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   endgenerate

   AST_PRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt == '0)); // R9

   AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R2
endmodule

// File: rtl/rtc_phase_seq.sv
module rtc_phase_seq
   import rtc_upd_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned WARN_TICKS    = 8,
   parameter int unsigned UPD_TICKS     = 65,
   parameter int unsigned PW            = $clog2(TICKS_PER_SEC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          hold,
   input  logic          kill,
   input  logic [PW-1:0] pre,
   output upd_phase_e    phase,
   output logic          advance,
   output logic          update_end
);
   localparam int unsigned WIN_MAX = (WARN_TICKS > UPD_TICKS) ? WARN_TICKS : UPD_TICKS;
   localparam int unsigned WW      = $clog2(WIN_MAX + 1);
   localparam logic [PW-1:0] START_PT  = PW'(TICKS_PER_SEC - WARN_TICKS - 1);
   localparam logic [WW-1:0] WARN_LAST = WW'(WARN_TICKS - 1);
   localparam logic [WW-1:0] UPD_LAST  = WW'(UPD_TICKS - 1);

   logic [WW-1:0] win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         win        <= '0;
         advance    <= 1'b0;
         update_end <= 1'b0;
      end else begin
         advance    <= 1'b0;
         update_end <= 1'b0;
         if (kill) begin
            phase <= PH_IDLE;
            win   <= '0;
         end else begin
            unique case (phase)
               PH_IDLE: begin
                  if (tick && !hold && (pre == START_PT)) begin
                     phase <= PH_WARN;
                     win   <= '0;
                  end
               end
               PH_WARN: begin
                  if (hold) begin
                     phase <= PH_IDLE;
                     win   <= '0;
                  end else if (tick) begin
                     if (win == WARN_LAST) begin
                        phase   <= PH_UPDATE;
                        win     <= '0;
                        advance <= 1'b1;
                     end else begin
                        win <= win + 1'b1;
                     end
                  end
               end
               PH_UPDATE: begin
                  if (tick) begin
                     if (win == UPD_LAST) begin
                        phase      <= PH_IDLE;
                        win        <= '0;
                        update_end <= 1'b1;
                     end else begin
                        win <= win + 1'b1;
                     end
                  end
               end
               default: begin
                  phase <= PH_IDLE;
                  win   <= '0;
               end
            endcase
         end
      end
   end

   AST_ADV_FROM_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> (phase == PH_UPDATE && $past(phase) == PH_WARN)); // R4

   AST_END_FROM_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      update_end |-> (phase == PH_IDLE && $past(phase) == PH_UPDATE)); // R5

   AST_SET_ABORTS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WARN && hold) |=> (phase == PH_IDLE && !advance)); // R7

   AST_SET_KEEPS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UPDATE && hold && !kill && !tick) |=> (phase == PH_UPDATE)); // R8

   AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (phase == PH_IDLE && !advance && !update_end)); // R10

   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WARN) |-> (win <= WARN_LAST)); // R3

   AST_WIN_BOUND_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UPDATE) |-> (win <= UPD_LAST)); // R5
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
   import rtc_upd_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned WARN_TICKS    = 8,
   parameter int unsigned UPD_TICKS     = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic set_mode,
   input  logic div_reset,
   output logic uip,
   output logic advance,
   output logic update_end
);
   localparam int unsigned PW = $clog2(TICKS_PER_SEC);

   initial begin
      AST_CFG_NONZERO: assert (WARN_TICKS >= 1 && UPD_TICKS >= 1)
         else $error("phase lengths must be nonzero"); // R6
      AST_CFG_GAP: assert (TICKS_PER_SEC > 2 * WARN_TICKS + UPD_TICKS)
         else $error("second too short for warn, window and idle gap"); // R6
   end

   logic [PW-1:0] pre;
   upd_phase_e    phase;
   logic          pre_hold;

   assign pre_hold = set_mode | div_reset;

   rtc_sec_prescaler #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .PW           (PW)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .hold (pre_hold),
      .cnt  (pre)
   );

   rtc_phase_seq #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .WARN_TICKS   (WARN_TICKS),
      .UPD_TICKS    (UPD_TICKS),
      .PW           (PW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .hold      (set_mode),
      .kill      (div_reset),
      .pre       (pre),
      .phase     (phase),
      .advance   (advance),
      .update_end(update_end)
   );

   assign uip = (phase != PH_IDLE) && !div_reset;

   AST_UIP_DIVRST: assert property (@(posedge clk) disable iff (!rst_n)
      (div_reset && $past(div_reset)) |-> (!uip && phase == PH_IDLE)); // R10

   AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(advance && update_end)); // R4
endmodule

// File: tb/tb_rtc_update_seq.sv
`timescale 1ns/1ps
module tb_rtc_update_seq;
   localparam int unsigned TPS  = 40;
   localparam int unsigned WARN = 8;
   localparam int unsigned UPD  = 12;

   logic clk = 1'b0;
   logic rst_n, tick, set_mode, div_reset;
   logic uip, advance, update_end;

   int total = 0;
   int bad   = 0;
   int adv_seen, end_seen;

   always #4 clk = ~clk;

   rtc_update_seq #(
      .TICKS_PER_SEC(TPS),
      .WARN_TICKS   (WARN),
      .UPD_TICKS    (UPD)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .set_mode  (set_mode),
      .div_reset (div_reset),
      .uip       (uip),
      .advance   (advance),
      .update_end(update_end)
   );

   typedef struct packed {
      logic [7:0] n;
      logic       st;
      logic       dv;
      logic [3:0] adv;
      logic [3:0] ends;
      logic       u;
   } vec_t;

   // ticks, set_mode, div_reset, expected advances, ends, final uip
   localparam vec_t VECS [12] = '{
      '{8'd31,  1'b0, 1'b0, 4'd0, 4'd0, 1'b0},  // R3 just before warn
      '{8'd1,   1'b0, 1'b0, 4'd0, 4'd0, 1'b1},  // R3 warn starts
      '{8'd8,   1'b0, 1'b0, 4'd1, 4'd0, 1'b1},  // R2 R4 strobe at boundary
      '{8'd11,  1'b0, 1'b0, 4'd0, 4'd0, 1'b1},  // R5 window still open
      '{8'd1,   1'b0, 1'b0, 4'd0, 4'd1, 1'b0},  // R5 window closes
      '{8'd40,  1'b0, 1'b0, 4'd1, 4'd1, 1'b0},  // R2 R6 next second
      '{8'd100, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0},  // R9 held
      '{8'd39,  1'b0, 1'b0, 4'd0, 4'd0, 1'b1},  // R9 one tick short
      '{8'd1,   1'b0, 1'b0, 4'd1, 4'd0, 1'b1},  // R9 full second later
      '{8'd5,   1'b0, 1'b1, 4'd0, 4'd0, 1'b0},  // R10 kill open window
      '{8'd40,  1'b0, 1'b0, 4'd1, 4'd0, 1'b1},  // R10 restart full second
      '{8'd12,  1'b0, 1'b0, 4'd0, 4'd1, 1'b0}   // R5 close
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one tick: raised for one clock, outputs sampled at the following negedge
   task automatic step();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (advance)    adv_seen++;
      if (update_end) end_seen++;
   endtask

   task automatic run(input int n);
      adv_seen = 0;
      end_seen = 0;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; set_mode = 1'b0; div_reset = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; set_mode = 1'b0; div_reset = 1'b0;
      do_reset();
      @(negedge clk);
      chk("R1 uip", int'(uip), 0);
      chk("R1 advance", int'(advance), 0);
      chk("R1 update_end", int'(update_end), 0);

      for (int v = 0; v < 12; v++) begin
         set_mode  = VECS[v].st;
         div_reset = VECS[v].dv;
         run(int'(VECS[v].n));
         chk($sformatf("R2-vec%0d advances", v), adv_seen, int'(VECS[v].adv));
         chk($sformatf("R5-vec%0d ends", v), end_seen, int'(VECS[v].ends));
         chk($sformatf("R3-vec%0d uip", v), int'(uip), int'(VECS[v].u));
      end
      set_mode = 1'b0; div_reset = 1'b0;

      // R7: set mode in warning aborts the cycle
      do_reset();
      run(33);
      chk("R7 uip before set", int'(uip), 1);
      set_mode = 1'b1;
      @(negedge clk);
      chk("R7 uip after one clock", int'(uip), 0);
      run(20);
      chk("R7 no advance", adv_seen, 0);
      chk("R7 no end", end_seen, 0);
      set_mode = 1'b0;
      run(40);
      chk("R9 advance after release", adv_seen, 1);

      // R8: set mode in window lets it finish
      do_reset();
      run(45);
      chk("R8 in window", int'(uip), 1);
      set_mode = 1'b1;
      run(10);
      chk("R8 end still fires", end_seen, 1);
      chk("R8 no extra advance", adv_seen, 0);
      chk("R8 uip low", int'(uip), 0);
      set_mode = 1'b0;

      // R10: divider reset masks uip in the same clock
      do_reset();
      run(35);
      chk("R10 uip before kill", int'(uip), 1);
      @(negedge clk);
      div_reset = 1'b1;
      #1;
      chk("R10 uip same clock", int'(uip), 0);
      run(3);
      div_reset = 1'b0;
      @(negedge clk);
      chk("R10 uip after release", int'(uip), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule